// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block collects five interrupt sources and turns them into two prioritized request lines for a processor core. The sources are three asynchronous external pins with a selectable edge, a four-bit input group watched for any change, and an internal 16-bit timer whose overflow can be taken at 8 or 16 bits. Every source owns a sticky flag and an enable bit. Every source except external pin 0 owns a routing bit that sends it to the high or the low request. Pin 0 always goes to the high request.

Software reaches the configuration, the flags, the watched inputs and the timer through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. Register map, by address: 0 control, 1 enables, 2 routing, 3 flags, 4 watched inputs, 5 timer low byte, 6 timer high byte. Source bit positions in registers 1 to 3 are the same throughout: bits 0 to 2 are external pins 0 to 2, bit 3 is the change detector, and bit 4 is the timer. In the control register, bit 0 is the global enable, bit 1 selects 16-bit timer mode, and bits 4:2 are the edge selects for pins 2:0.

A wake pulse tells a sleeping core that an enabled external source has fired, whether or not the global enable is set. A separate branch qualifier says whether the core should also take the vector.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Each external pin is synchronized and edge-detected. Its edge-select bit (control bits 4:2 for pins 2:0) picks rising edges when 1 and falling edges when 0. The opposite edge leaves the flag clear. A detected edge sets the flag within four clock cycles of the pin change.
- R2: A flag stays set, whatever its enable bit, until software writes a 1 to its bit in the flag register (address 3). Writing 0 leaves the bit unchanged.
- R3: When a software clear and a new hardware event for the same source fall in the same cycle, the flag remains set.
- R4: External pin 0 always routes to the high request, and routing bit 0 reads as 1. Routing bits 1 to 4 send their source to the high request when 1 and to the low request when 0.
- R5: The change flag (bit 3) is set while the synchronized 4-bit inputs differ from a snapshot. A read of address 4 returns the synchronized inputs and loads the snapshot with them, so a later clear can stick.
- R6: In 8-bit mode (control bit 1 = 0), each tick increments only the timer low byte. A wrap from FFh to 00h sets the timer flag (bit 4) and leaves the high byte unchanged.
- R7: In 16-bit mode, each tick increments the whole 16-bit count. The timer flag is set only on the wrap from FFFFh to 0000h.
- R8: The high request is the registered OR of the flags that are enabled and routed high. The low request is the same for flags routed low. A disabled flag drives neither.
- R9: The branch qualifier is high only when the global enable is set and at least one enabled flag is set.
- R10: While sleepIn is high, the wake output gives a single one-cycle pulse when an enabled external flag first becomes active, independent of the global enable.
- R11: After reset, all configuration, flags and timer bytes are 0, the routing register reads 01h, and all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 3 | Asynchronous external interrupt pins |
| portIn | input | 4 | Asynchronous inputs watched for change |
| tmrTick | input | 1 | Timer count enable, one increment per cycle |
| sleepIn | input | 1 | Core is in low-power mode |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| hiReq | output | 1 | High-priority interrupt request |
| loReq | output | 1 | Low-priority interrupt request |
| vecBranch | output | 1 | Branch-to-vector qualifier |
| wakePulse | output | 1 | One-cycle wake-up pulse |

## Verification
Some properties are checked on every cycle:
- Flags stay set unless a clear strobe is present.
- An armed pin 0 flag always raises the high request.
- Each request is traceable to an enabled flag on its own route.
- The branch qualifier never rises without the global enable.
- Wake pulses last one cycle and occur only during sleep.

Other behaviour needs the bench's scenarios:
- Edge polarity selection.
- Snapshot-based change detection.
- Same-cycle clear against a persisting event.
- The 8-bit and 16-bit timer wrap points.
- The exact count of wake pulses.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int NUM_EXT = 3;
  localparam int CHG_W   = 4;
  localparam int DATA_W  = 8;
  localparam int TMR_W   = 2 * DATA_W;
  localparam int ADDR_W  = 3;
  localparam int NUM_SRC = NUM_EXT + 2;
  localparam int SRC_CHG = NUM_EXT;
  localparam int SRC_TMR = NUM_EXT + 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRIO = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_PORT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TMRL = 3'd5;
  localparam logic [ADDR_W-1:0] A_TMRH = 3'd6;

  typedef struct packed {
    logic [NUM_SRC-1:0] flagClr;
    logic               snapLoad;
    logic               tmrLoWr;
    logic               tmrHiWr;
    logic [DATA_W-1:0]  data;
  } strobe_t;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [CHG_W-1:0]   portSync,
  input  logic [TMR_W-1:0]   tmrCnt,
  output logic               globalEn,
  output logic               mode16,
  output logic [NUM_EXT-1:0] edgeSel,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_SRC-1:0] routeHi,
  output strobe_t            strobe
);
  logic [NUM_SRC-1:1] prioQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      mode16   <= 1'b0;
      edgeSel  <= '0;
      srcEn    <= '0;
      prioQ    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL: begin
          globalEn <= regWrData[0];
          mode16   <= regWrData[1];
          edgeSel  <= regWrData[NUM_EXT+1:2];
        end
        A_EN:    srcEn <= regWrData[NUM_SRC-1:0];
        A_PRIO:  prioQ <= regWrData[NUM_SRC-1:1];
        default: ;
      endcase
    end
  end

  // pin 0 carries no routing bit: it is wired to the high request
  assign routeHi = {prioQ, 1'b1};

  always_comb begin
    strobe.flagClr  = (regWrEn && regAddr == A_FLAG) ? regWrData[NUM_SRC-1:0] : '0;
    strobe.snapLoad = regRdEn && (regAddr == A_PORT);
    strobe.tmrLoWr  = regWrEn && (regAddr == A_TMRL);
    strobe.tmrHiWr  = regWrEn && (regAddr == A_TMRH);
    strobe.data     = regWrData;
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = {{(DATA_W-2-NUM_EXT){1'b0}}, edgeSel, mode16, globalEn};
      A_EN:    regRdData = {{(DATA_W-NUM_SRC){1'b0}}, srcEn};
      A_PRIO:  regRdData = {{(DATA_W-NUM_SRC){1'b0}}, routeHi};
      A_FLAG:  regRdData = {{(DATA_W-NUM_SRC){1'b0}}, flags};
      A_PORT:  regRdData = {{(DATA_W-CHG_W){1'b0}}, portSync};
      A_TMRL:  regRdData = tmrCnt[DATA_W-1:0];
      A_TMRH:  regRdData = tmrCnt[TMR_W-1:DATA_W];
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [CHG_W-1:0]   portIn,
  input  logic               tmrTick,
  input  logic               sleepIn,
  input  logic               globalEn,
  input  logic               mode16,
  input  logic [NUM_EXT-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] routeHi,
  input  strobe_t            strobe,
  output logic [NUM_SRC-1:0] flags,
  output logic [CHG_W-1:0]   portSync,
  output logic [TMR_W-1:0]   tmrCnt,
  output logic               hiReq,
  output logic               loReq,
  output logic               vecBranch,
  output logic               wakePulse
);
  localparam logic [DATA_W-1:0] ONE_B = DATA_W'(1);
  localparam logic [TMR_W-1:0]  ONE_W = TMR_W'(1);

  logic [NUM_EXT-1:0] extSync, extPrev, extEvt;
  logic [CHG_W-1:0]   snap;
  logic               chgEvt, tmrOvf, tmrWr, wakeCond, wakeQ;
  logic [NUM_SRC-1:0] srcEvt, armed;

  irqc_sync #(.W(NUM_EXT), .STAGES(2)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extPin), .dout(extSync));
  irqc_sync #(.W(CHG_W), .STAGES(2)) u_portSync (
    .clk(clk), .rstN(rstN), .din(portIn), .dout(portSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= '0;
    else       extPrev <= extSync;
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
    assign extEvt[i] = edgeSel[i] ? (extSync[i] & ~extPrev[i])
                                  : (~extSync[i] & extPrev[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                snap <= '0;
    else if (strobe.snapLoad) snap <= portSync;
  end
  assign chgEvt = |(portSync ^ snap);

  assign tmrWr  = strobe.tmrLoWr | strobe.tmrHiWr;
  assign tmrOvf = tmrTick && !tmrWr &&
                  (mode16 ? (&tmrCnt) : (&tmrCnt[DATA_W-1:0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (tmrWr) begin
      if (strobe.tmrLoWr) tmrCnt[DATA_W-1:0]     <= strobe.data;
      if (strobe.tmrHiWr) tmrCnt[TMR_W-1:DATA_W] <= strobe.data;
    end else if (tmrTick) begin
      if (mode16) tmrCnt <= tmrCnt + ONE_W;
      else        tmrCnt[DATA_W-1:0] <= tmrCnt[DATA_W-1:0] + ONE_B;
    end
  end

  assign srcEvt = {tmrOvf, chgEvt, extEvt};

  // a hardware event outranks a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~strobe.flagClr) | srcEvt;
  end

  assign armed    = flags & srcEn;
  assign wakeCond = |armed[NUM_EXT-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReq     <= 1'b0;
      loReq     <= 1'b0;
      vecBranch <= 1'b0;
      wakeQ     <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      hiReq     <= |(armed & routeHi);
      loReq     <= |(armed & ~routeHi);
      vecBranch <= globalEn && (|armed);
      wakeQ     <= wakeCond;
      wakePulse <= sleepIn && wakeCond && !wakeQ;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [CHG_W-1:0]   portIn,
  input  logic               tmrTick,
  input  logic               sleepIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               hiReq,
  output logic               loReq,
  output logic               vecBranch,
  output logic               wakePulse
);
  logic               globalEn, mode16;
  logic [NUM_EXT-1:0] edgeSel;
  logic [NUM_SRC-1:0] srcEn, routeHi, flagsQ;
  logic [CHG_W-1:0]   portSync;
  logic [TMR_W-1:0]   tmrCnt;
  strobe_t            strobe;

  irqc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .flags(flagsQ), .portSync(portSync), .tmrCnt(tmrCnt),
    .globalEn(globalEn), .mode16(mode16), .edgeSel(edgeSel),
    .srcEn(srcEn), .routeHi(routeHi), .strobe(strobe));

  irqc_datapath u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portIn(portIn),
    .tmrTick(tmrTick), .sleepIn(sleepIn), .globalEn(globalEn),
    .mode16(mode16), .edgeSel(edgeSel), .srcEn(srcEn), .routeHi(routeHi),
    .strobe(strobe), .flags(flagsQ), .portSync(portSync), .tmrCnt(tmrCnt),
    .hiReq(hiReq), .loReq(loReq), .vecBranch(vecBranch),
    .wakePulse(wakePulse));
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
`timescale 1ns/1ps
module irq_flag_ctrl_chk
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] srcEn,
  input logic [NUM_SRC-1:0] routeHi,
  input logic [NUM_SRC-1:0] flagClr,
  input logic               globalEn,
  input logic               sleepIn,
  input logic               hiReq,
  input logic               loReq,
  input logic               vecBranch,
  input logic               wakePulse
);
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr)));

  p_int0_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && srcEn[0]) |=> hiReq);

  p_hi_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    hiReq |-> $past(|(flags & srcEn & routeHi)));

  p_lo_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    loReq |-> $past(|(flags & srcEn & ~routeHi)));

  p_vec_global_r9: assert property (@(posedge clk) disable iff (!rstN)
    vecBranch |-> $past(globalEn));

  p_wake_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  p_wake_sleep_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(sleepIn));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .flags(flagsQ), .srcEn(srcEn), .routeHi(routeHi),
  .flagClr(strobe.flagClr), .globalEn(globalEn), .sleepIn(sleepIn),
  .hiReq(hiReq), .loReq(loReq), .vecBranch(vecBranch), .wakePulse(wakePulse));

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] extPin = '0;
  logic [3:0] portIn = '0;
  logic       tmrTick = 1'b0, sleepIn = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       hiReq, loReq, vecBranch, wakePulse;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl u_dut (.*);

  // fields: edge[23:21] en[20:16] prio[15:11] pinStart[10:8] pinEnd[7:5] expFlags[4:2] hi[1] lo[0]
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {3'b111, 5'b00111, 5'b00000, 3'b000, 3'b111, 3'b111, 1'b1, 1'b1},
    {3'b000, 5'b00111, 5'b00110, 3'b111, 3'b000, 3'b111, 1'b1, 1'b0},
    {3'b000, 5'b00110, 5'b00000, 3'b000, 3'b111, 3'b000, 1'b0, 1'b0},
    {3'b010, 5'b00010, 5'b00000, 3'b000, 3'b010, 3'b010, 1'b0, 1'b1},
    {3'b101, 5'b00000, 5'b00000, 3'b000, 3'b101, 3'b101, 1'b0, 1'b0},
    {3'b100, 5'b00001, 5'b00100, 3'b000, 3'b100, 3'b100, 1'b0, 1'b0},
    {3'b001, 5'b00101, 5'b00100, 3'b000, 3'b001, 3'b001, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk); tmrTick = 1'b1;
    @(negedge clk); tmrTick = 1'b0;
  endtask

  task automatic countWake(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (wakePulse) c++; end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int w;
    cyc(4);
    rstN = 1'b1;
    cyc(2);
    // R11 reset state
    rd(3'd0, d); check("R11 ctrl", d, 8'h00);
    rd(3'd1, d); check("R11 enable", d, 8'h00);
    rd(3'd2, d); check("R11 routing", d, 8'h01);
    rd(3'd3, d); check("R11 flags", d, 8'h00);
    rd(3'd5, d); check("R11 timer", d, 8'h00);
    check("R11 outputs", {hiReq, loReq, vecBranch, wakePulse}, 4'b0000);

    // vector table: R1 edge select, R2 sticky, R4 routing, R8 requests
    for (int v = 0; v < NV; v++) begin
      extPin = VEC[v][10:8];
      wr(3'd0, {3'b000, VEC[v][23:21], 2'b01});
      wr(3'd1, {3'b000, VEC[v][20:16]});
      wr(3'd2, {3'b000, VEC[v][15:11]});
      cyc(6);
      wr(3'd3, 8'h1F);
      cyc(2);
      @(negedge clk); extPin = VEC[v][7:5];
      cyc(6);
      rd(3'd3, d);
      check("R1/R2 ext flags", d, {5'b0, VEC[v][4:2]});
      check("R4/R8 hiReq", hiReq, VEC[v][1]);
      check("R4/R8 loReq", loReq, VEC[v][0]);
      check("R9 vecBranch", vecBranch, VEC[v][1] | VEC[v][0]);
    end

    // R5 / R3: change detector with snapshot
    wr(3'd3, 8'h1F);
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h08);
    @(negedge clk); portIn = 4'hA;
    cyc(6);
    rd(3'd3, d); check("R5 change flag set", d, 8'h08);
    check("R8 change high", hiReq, 1'b1);
    wr(3'd3, 8'h08);
    cyc(2);
    rd(3'd3, d); check("R3 clear vs live event", d, 8'h08);
    rd(3'd4, d); check("R5 port read", d, 8'h0A);
    cyc(2);
    wr(3'd3, 8'h08);
    cyc(3);
    rd(3'd3, d); check("R5 clear after snapshot", d, 8'h00);
    check("R8 change dropped", hiReq, 1'b0);
    wr(3'd3, 8'h00);
    cyc(2);
    @(negedge clk); portIn = 4'h2;
    cyc(6);
    rd(3'd3, d); check("R2 zero write keeps flag", d, 8'h08);

    // R6: 8-bit timer
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd6, 8'h12);
    wr(3'd5, 8'hFE);
    wr(3'd3, 8'h1F);
    rd(3'd4, d);
    wr(3'd3, 8'h1F);
    tick; cyc(2);
    rd(3'd3, d); check("R6 no flag at FF", d, 8'h00);
    rd(3'd5, d); check("R6 low byte FF", d, 8'hFF);
    tick; cyc(2);
    rd(3'd3, d); check("R6 wrap flag", d, 8'h10);
    rd(3'd5, d); check("R6 low byte 00", d, 8'h00);
    rd(3'd6, d); check("R6 high byte kept", d, 8'h12);
    check("R8 timer low route", {hiReq, loReq}, 2'b01);

    // R7: 16-bit timer
    wr(3'd0, 8'h03);
    wr(3'd3, 8'h1F);
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hFF);
    tick; cyc(2);
    rd(3'd3, d); check("R7 no flag at 00FF", d, 8'h00);
    rd(3'd6, d); check("R7 carry to high", d, 8'h01);
    wr(3'd6, 8'hFF);
    wr(3'd5, 8'hFF);
    tick; cyc(2);
    rd(3'd3, d); check("R7 wrap flag", d, 8'h10);
    rd(3'd6, d); check("R7 high byte 00", d, 8'h00);

    // R9: global enable gates only the branch qualifier
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h04);
    @(negedge clk); extPin = 3'b000;
    cyc(6);
    wr(3'd3, 8'h1F);
    @(negedge clk); extPin = 3'b001;
    cyc(6);
    check("R9 hiReq without global", hiReq, 1'b1);
    check("R9 no branch without global", vecBranch, 1'b0);
    wr(3'd0, 8'h05);
    cyc(3);
    check("R9 branch with global", vecBranch, 1'b1);

    // R10: wake pulse
    wr(3'd0, 8'h04);
    sleepIn = 1'b1;
    @(negedge clk); extPin = 3'b000;
    cyc(6);
    wr(3'd3, 8'h1F);
    cyc(3);
    @(negedge clk); extPin = 3'b001;
    countWake(10, w);
    check("R10 one wake pulse", w, 1);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h1F);
    @(negedge clk); extPin = 3'b000;
    cyc(4);
    @(negedge clk); extPin = 3'b001;
    countWake(10, w);
    check("R10 no wake when disabled", w, 0);
    rd(3'd3, d); check("R2 flag set while disabled", d, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule